// File: doc/BRIEF.md
# Buffered Tick Prescaler

This block divides a timer clock down to a single-cycle tick enable for a downstream counter. While the run input is high, the tick fires once every (N + 1) clock cycles, where N is the active divide value. With a 16-bit value this gives division factors from 1 to 65536.

Software writes a new divide value into a preload register at any time. The active value is copied from that preload only when an update strobe arrives, so a ratio change never cuts a period short and never stretches one. The update strobe also restarts the internal phase counter.

A separate reinit strobe restarts the phase counter without touching the active ratio. It serves the case where updates are suppressed but the counting chain still has to be realigned.

Top module: `tick_divider`

## Requirements
- R1: With active value N and run held high, the tick is high on exactly one cycle in every N + 1 cycles.
- R2: A preload write alone leaves the active value unchanged; the tick period stays the same until an update strobe.
- R3: The phase counter runs 0, 1, ..., N and then returns to 0. The tick is high in the cycle in which the phase equals N, so the first tick after a restart arrives on the (N + 1)th enabled cycle.
- R4: A reinit strobe, with no update strobe, sets the phase to 0 and keeps the active value.
- R5: An update strobe copies the preload into the active value and sets the phase to 0, both effective in the next cycle.
- R6: While run is low, the tick stays low and the phase holds its value. Counting resumes from that phase when run returns high.
- R7: After reset the preload, the active value and the phase are all 0, which means divide by 1.
- R8: With active value 0, the tick is high on every cycle in which run is high.
- R9: When an update strobe falls in the cycle of a tick, that tick is still issued and the next period uses the new ratio, starting from phase 0.
- R10: When a preload write and an update strobe share a cycle, the update transfers the preload value held before that write, and the newly written value waits for the next update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Enables the prescaler to advance and tick |
| pre_we | input | 1 | Preload write strobe |
| pre_wdata | input | W | Divide value to preload (ratio minus one) |
| upd | input | 1 | Update strobe: loads the active ratio and clears the phase |
| reinit | input | 1 | Clears the phase and keeps the ratio |
| tick | output | 1 | One-cycle enable for the counter |

## Verification
The assertions assume that every strobe is synchronous and lasts one cycle per intended event. They also assume that the phase is never observed under a ratio it has already passed. This holds because the ratio changes only together with a phase clear. The bench drives every input at the falling edge and samples the tick one nanosecond later. Every strobe therefore settles well before the rising edge that consumes it. The expected tick positions are derived from the phase sequence in the requirements and compared cycle by cycle.

// File: rtl/tick_divider.sv
`timescale 1ns/1ps
module tick_divider #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         pre_we,
  input  logic [W-1:0] pre_wdata,
  input  logic         upd,
  input  logic         reinit,
  output logic         tick
);

  logic [W-1:0] pre_q;
  logic [W-1:0] ratio_q;
  logic [W-1:0] ph_q;
  logic         wrap;

  assign wrap = (ph_q == ratio_q);
  assign tick = run && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (pre_we) begin
      pre_q <= pre_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_q <= '0;
    end else if (upd) begin
      ratio_q <= pre_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0;
    end else if (upd || reinit) begin
      ph_q <= '0;
    end else if (run) begin
      ph_q <= wrap ? '0 : ph_q + 1'b1;
    end
  end

endmodule

module tick_divider_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run,
  input logic         upd,
  input logic         reinit,
  input logic         tick,
  input logic [W-1:0] pre_q,
  input logic [W-1:0] ratio_q,
  input logic [W-1:0] ph_q
);

  // R1
  tick_wraps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !upd && !reinit) |=> (ph_q == '0));

  // R2
  ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(ratio_q));

  // R3
  phase_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q <= ratio_q);

  // R4
  reinit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reinit && !upd) |=> (ph_q == '0) && $stable(ratio_q));

  // R5
  update_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (ratio_q == $past(pre_q)) && (ph_q == '0));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !upd && !reinit) |=> $stable(ph_q));

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick);

endmodule

bind tick_divider tick_divider_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .upd(upd), .reinit(reinit),
  .tick(tick), .pre_q(pre_q), .ratio_q(ratio_q), .ph_q(ph_q)
);

// File: tb/test_tick_divider.sv
`timescale 1ns/1ps
module test_tick_divider;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         run = 1'b0;
  logic         pre_we = 1'b0;
  logic [W-1:0] pre_wdata = '0;
  logic         upd = 1'b0;
  logic         reinit = 1'b0;
  logic         tick;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic seen;

  always #2 clk = ~clk;

  tick_divider #(.W(W)) i_tick_divider (
    .clk(clk), .rst_n(rst_n), .run(run), .pre_we(pre_we),
    .pre_wdata(pre_wdata), .upd(upd), .reinit(reinit), .tick(tick)
  );

  task automatic step(input bit r, input bit u, input bit ri,
                      input bit we, input logic [W-1:0] d);
    @(negedge clk);
    run = r; upd = u; reinit = ri; pre_we = we; pre_wdata = d;
    #1 seen = tick;
  endtask

  task automatic chk(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: tick=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic chk_int(input int act, input int exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: value=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    step(0, 0, 0, 0, '0);
    chk(seen, 1'b0, "R7 idle after reset");
    for (int i = 0; i < 6; i++) begin
      step(1, 0, 0, 0, '0);
      chk(seen, 1'b1, "R7 R8 divide by one after reset");
    end
  endtask

  task automatic t_load4();
    step(1, 0, 0, 1, 16'd3);
    chk(seen, 1'b1, "R2 write leaves ratio 0");
    step(1, 1, 0, 0, '0);
    chk(seen, 1'b1, "R5 update cycle still ratio 0");
    for (int i = 0; i < 12; i++) begin
      step(1, 0, 0, 0, '0);
      chk(seen, (i % 4) == 3, "R1 R3 R5 divide by four");
    end
  endtask

  task automatic t_hold();
    step(1, 0, 0, 0, '0);
    step(1, 0, 0, 0, '0);
    for (int i = 0; i < 5; i++) begin
      step(0, 0, 0, 0, '0);
      chk(seen, 1'b0, "R6 no tick while stopped");
    end
    step(1, 0, 0, 0, '0);
    chk(seen, 1'b0, "R6 resume at phase 2");
    step(1, 0, 0, 0, '0);
    chk(seen, 1'b1, "R6 resume reaches phase 3");
  endtask

  task automatic t_nopre();
    for (int i = 0; i < 8; i++) begin
      step(1, 0, 0, i == 0, 16'd1);
      chk(seen, (i % 4) == 3, "R2 period kept after preload write");
    end
  endtask

  task automatic t_reinit();
    step(1, 0, 0, 0, '0);
    step(1, 0, 0, 0, '0);
    step(1, 0, 1, 0, '0);
    chk(seen, 1'b0, "R4 reinit at phase 2");
    for (int i = 0; i < 4; i++) begin
      step(1, 0, 0, 0, '0);
      chk(seen, i == 3, "R4 phase restarted ratio kept");
    end
  endtask

  task automatic t_wrap_upd();
    step(1, 0, 0, 0, '0);
    step(1, 0, 0, 0, '0);
    step(1, 0, 0, 0, '0);
    step(1, 1, 0, 0, '0);
    chk(seen, 1'b1, "R9 tick kept under update");
    for (int i = 0; i < 4; i++) begin
      step(1, 0, 0, 0, '0);
      chk(seen, (i % 2) == 1, "R9 new ratio after coinciding update");
    end
  endtask

  task automatic t_same();
    step(1, 1, 0, 1, 16'd4);
    chk(seen, 1'b0, "R10 write with update");
    for (int i = 0; i < 4; i++) begin
      step(1, 0, 0, 0, '0);
      chk(seen, (i % 2) == 1, "R10 old preload transferred");
    end
    step(1, 1, 0, 0, '0);
    for (int i = 0; i < 10; i++) begin
      step(1, 0, 0, 0, '0);
      chk(seen, (i % 5) == 4, "R10 R1 new preload on next update");
    end
  endtask

  task automatic t_big();
    int n = 0;
    int first = -1;
    step(1, 0, 0, 1, 16'd99);
    step(1, 1, 0, 0, '0);
    for (int i = 0; i < 300; i++) begin
      step(1, 0, 0, 0, '0);
      if (seen === 1'b1) begin
        if (first < 0) first = i;
        n++;
      end
    end
    chk_int(first, 99, "R1 R3 first tick at divide by 100");
    chk_int(n, 3, "R1 tick count at divide by 100");
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: cycles=200000 expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_load4();
    t_hold();
    t_nopre();
    t_reinit();
    t_wrap_upd();
    t_same();
    t_big();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule